// File: doc/BRIEF.md
# NAND Page Layout Stream Splitter

This block takes the byte stream of one physical NAND page, spare area included, in the order the flash delivers it. It tags every byte as either payload or spare. Payload bytes leave on a data strobe with their index in the logical data buffer. Spare bytes leave on a spare strobe with their index in the logical spare buffer. A page-done pulse accompanies the final byte.

On the flash, the page opens with four metadata bytes. Data packets and their ECC fields then alternate. A six-byte bad-block-marker window sits at a physical offset equal to the configured page size, so it falls inside the last packet and splits that packet into a head and a tail. In the logical spare buffer the marker moves to the front. The metadata follows it, and then the ECC fields appear in packet order.

The position counters are meant to be shared with the write path, which walks the same layout. The configuration inputs are the page size, the packet size and the ECC bytes per packet. For a packet strength s the ECC byte count is ceil(15·s/8). These inputs are sampled at reset and again at every page boundary.

Top module: `nand_page_splitter`

## Requirements
- R1: During reset and in the cycle after it, `data_stb`, `spare_stb` and `page_done` are all low.
- R2: The first four accepted bytes of a page leave on `spare_stb` with indices 6, 7, 8, 9.
- R3: Bytes are handled in pairs of a full data packet (`cfg_pkt_bytes` data strobes) followed by its ECC field (`cfg_ecc_bytes` spare strobes). Such pairs repeat while the bytes left before physical offset `cfg_page_bytes` exceed one packet. ECC byte b of packet i gets spare index 10 + i·`cfg_ecc_bytes` + b.
- R4: The six bytes starting at physical offset `cfg_page_bytes` leave on `spare_stb` with indices 0 to 5, in order.
- R5: Data indices start at 0 on each page and rise by one per data byte, with no gap across the marker window.
- R6: The last packet is delivered in this order: the bytes left before the marker, then the marker, then the rest of the packet, then the last ECC field.
- R7: When the bytes left before the marker equal one whole packet, no tail follows the marker, and the last ECC field comes right after it.
- R8: `page_done` is high for exactly one cycle, together with the spare strobe of the last ECC byte.
- R9: Each byte accepted with `in_valid` produces exactly one strobe, one cycle later, carrying that byte on `out_byte`. A cycle with `in_valid` low produces no strobe and does not move the layout position.
- R10: The byte after a page-done starts a new page, with every index restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_page_bytes | input | 16 | Page size; physical offset of the marker window |
| cfg_pkt_bytes | input | 16 | Data bytes per packet |
| cfg_ecc_bytes | input | 16 | ECC bytes per packet (at least 1) |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Raw page byte |
| data_stb | output | 1 | Output byte is payload |
| data_idx | output | 16 | Logical data index |
| spare_stb | output | 1 | Output byte is spare |
| spare_idx | output | 16 | Logical spare index |
| out_byte | output | 8 | Routed byte |
| page_done | output | 1 | Last byte of the page |

## Verification
Two events can land in the same cycle. The page-done pulse always arrives together with the spare strobe of the final ECC byte. When pages run back to back, the first metadata byte of the next page follows in the very next cycle. The bench provokes both cases with continuous streams and with streams that have idle gaps. It predicts every cycle from a behavioural walk of the layout, and it judges each cycle on both strobes, both indices, the byte and the done flag at once.

// File: rtl/nand_split_pkg.sv
package nand_split_pkg;
    localparam int META_BYTES = 4;
    localparam int MARK_BYTES = 6;
    localparam int SEQ_BASE   = MARK_BYTES;

    typedef enum logic [2:0] {
        SEG_META, SEG_PKT, SEG_ECC, SEG_HEAD, SEG_MARK, SEG_TAIL, SEG_LAST_ECC
    } seg_e;

    typedef enum logic [1:0] {
        RT_NONE, RT_DATA, RT_MARK, RT_SEQ
    } route_e;

    typedef struct packed {
        route_e kind;
        logic   last;
    } route_t;

    function automatic route_e route_of(seg_e s);
        case (s)
            SEG_PKT, SEG_HEAD, SEG_TAIL:       return RT_DATA;
            SEG_MARK:                          return RT_MARK;
            SEG_META, SEG_ECC, SEG_LAST_ECC:   return RT_SEQ;
            default:                           return RT_NONE;
        endcase
    endfunction
endpackage

// File: rtl/nsp_segment_fsm.sv
module nsp_segment_fsm
    import nand_split_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cfg_page,
    input  logic [W-1:0] cfg_pkt,
    input  logic [W-1:0] cfg_ecc,
    input  logic         adv,
    output route_t       route_o
);
    seg_e         seg_q;
    logic [W-1:0] left_q;
    logic [W-1:0] mark_q;
    logic [W-1:0] head_q;
    logic [W-1:0] mark_dec;
    logic         pre_mark;

    assign mark_dec = mark_q - W'(1);
    assign pre_mark = (seg_q == SEG_META) || (seg_q == SEG_PKT) ||
                      (seg_q == SEG_ECC)  || (seg_q == SEG_HEAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q  <= SEG_META;
            left_q <= W'(META_BYTES - 1);
            mark_q <= cfg_page;
            head_q <= '0;
        end else if (adv) begin
            if (pre_mark) mark_q <= mark_dec;
            if (left_q != '0) begin
                left_q <= left_q - W'(1);
            end else begin
                case (seg_q)
                    SEG_META, SEG_ECC: begin
                        if (mark_dec > cfg_pkt) begin
                            seg_q  <= SEG_PKT;
                            left_q <= cfg_pkt - W'(1);
                        end else begin
                            seg_q  <= SEG_HEAD;
                            left_q <= mark_dec - W'(1);
                            head_q <= mark_dec;
                        end
                    end
                    SEG_PKT: begin
                        seg_q  <= SEG_ECC;
                        left_q <= cfg_ecc - W'(1);
                    end
                    SEG_HEAD: begin
                        seg_q  <= SEG_MARK;
                        left_q <= W'(MARK_BYTES - 1);
                    end
                    SEG_MARK: begin
                        if (head_q < cfg_pkt) begin
                            seg_q  <= SEG_TAIL;
                            left_q <= cfg_pkt - head_q - W'(1);
                        end else begin
                            seg_q  <= SEG_LAST_ECC;
                            left_q <= cfg_ecc - W'(1);
                        end
                    end
                    SEG_TAIL: begin
                        seg_q  <= SEG_LAST_ECC;
                        left_q <= cfg_ecc - W'(1);
                    end
                    default: begin
                        seg_q  <= SEG_META;
                        left_q <= W'(META_BYTES - 1);
                        mark_q <= cfg_page;
                    end
                endcase
            end
        end
    end

    always_comb begin
        route_o.kind = adv ? route_of(seg_q) : RT_NONE;
        route_o.last = adv && (seg_q == SEG_LAST_ECC) && (left_q == '0);
    end
endmodule

// File: rtl/nsp_index_gen.sv
module nsp_index_gen
    import nand_split_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  route_t       route_i,
    input  logic [7:0]   byte_i,
    output logic         data_stb,
    output logic [W-1:0] data_idx,
    output logic         spare_stb,
    output logic [W-1:0] spare_idx,
    output logic [7:0]   out_byte,
    output logic         page_done
);
    logic [W-1:0] data_cnt, mark_cnt, seq_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_cnt  <= '0;
            mark_cnt  <= '0;
            seq_cnt   <= W'(SEQ_BASE);
            data_stb  <= 1'b0;
            spare_stb <= 1'b0;
            page_done <= 1'b0;
            data_idx  <= '0;
            spare_idx <= '0;
            out_byte  <= '0;
        end else begin
            data_stb  <= (route_i.kind == RT_DATA);
            spare_stb <= (route_i.kind == RT_MARK) || (route_i.kind == RT_SEQ);
            page_done <= route_i.last;
            if (route_i.kind != RT_NONE) out_byte <= byte_i;
            case (route_i.kind)
                RT_DATA: begin
                    data_idx <= data_cnt;
                    data_cnt <= data_cnt + W'(1);
                end
                RT_MARK: begin
                    spare_idx <= mark_cnt;
                    mark_cnt  <= mark_cnt + W'(1);
                end
                RT_SEQ: begin
                    spare_idx <= seq_cnt;
                    seq_cnt   <= seq_cnt + W'(1);
                end
                default: ;
            endcase
            if (route_i.last) begin
                data_cnt <= '0;
                mark_cnt <= '0;
                seq_cnt  <= W'(SEQ_BASE);
            end
        end
    end
endmodule

// File: rtl/nand_page_splitter.sv
module nand_page_splitter
    import nand_split_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cfg_page_bytes,
    input  logic [W-1:0] cfg_pkt_bytes,
    input  logic [W-1:0] cfg_ecc_bytes,
    input  logic         in_valid,
    input  logic [7:0]   in_byte,
    output logic         data_stb,
    output logic [W-1:0] data_idx,
    output logic         spare_stb,
    output logic [W-1:0] spare_idx,
    output logic [7:0]   out_byte,
    output logic         page_done
);
    route_t route;

    nsp_segment_fsm #(.W(W)) seg_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_page (cfg_page_bytes),
        .cfg_pkt  (cfg_pkt_bytes),
        .cfg_ecc  (cfg_ecc_bytes),
        .adv      (in_valid),
        .route_o  (route)
    );

    nsp_index_gen #(.W(W)) idx_i (
        .clk       (clk),
        .rst       (rst),
        .route_i   (route),
        .byte_i    (in_byte),
        .data_stb  (data_stb),
        .data_idx  (data_idx),
        .spare_stb (spare_stb),
        .spare_idx (spare_idx),
        .out_byte  (out_byte),
        .page_done (page_done)
    );
endmodule

// File: rtl/nand_page_splitter_chk.sv
module nand_page_splitter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         data_stb,
    input logic [W-1:0] data_idx,
    input logic         spare_stb,
    input logic [W-1:0] spare_idx,
    input logic         page_done
);
    logic [W-1:0] next_data, next_seq;

    always_ff @(posedge clk) begin
        if (rst || page_done) begin
            next_data <= '0;
            next_seq  <= W'(6);
        end else begin
            if (data_stb) next_data <= data_idx + W'(1);
            if (spare_stb && spare_idx >= W'(6)) next_seq <= spare_idx + W'(1);
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!data_stb && !spare_stb && !page_done));

    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(data_stb && spare_stb));

    a_r9_strobe_per_byte: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (data_stb || spare_stb));

    a_r9_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!data_stb && !spare_stb && !page_done));

    a_r8_done_on_spare: assert property (@(posedge clk) disable iff (rst)
        page_done |-> (spare_stb && spare_idx >= W'(10)));

    a_r5_data_contiguous: assert property (@(posedge clk) disable iff (rst)
        data_stb |-> (data_idx == next_data));

    a_r3_spare_sequence: assert property (@(posedge clk) disable iff (rst)
        (spare_stb && spare_idx >= W'(6)) |-> (spare_idx == next_seq));

    a_r4_marker_range: assert property (@(posedge clk) disable iff (rst)
        (spare_stb && spare_idx < W'(6)) |-> !page_done);
endmodule

bind nand_page_splitter nand_page_splitter_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .data_stb  (data_stb),
    .data_idx  (data_idx),
    .spare_stb (spare_stb),
    .spare_idx (spare_idx),
    .page_done (page_done)
);

// File: tb/nand_page_splitter_tb_top.sv
`timescale 1ns/1ps
module nand_page_splitter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_page_bytes = 16'd32;
    logic [15:0] cfg_pkt_bytes  = 16'd8;
    logic [15:0] cfg_ecc_bytes  = 16'd3;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'd0;
    logic        data_stb, spare_stb, page_done;
    logic [15:0] data_idx, spare_idx;
    logic [7:0]  out_byte;

    always #2.5 clk = ~clk;

    nand_page_splitter dut_i (
        .clk(clk), .rst(rst),
        .cfg_page_bytes(cfg_page_bytes), .cfg_pkt_bytes(cfg_pkt_bytes),
        .cfg_ecc_bytes(cfg_ecc_bytes),
        .in_valid(in_valid), .in_byte(in_byte),
        .data_stb(data_stb), .data_idx(data_idx),
        .spare_stb(spare_stb), .spare_idx(spare_idx),
        .out_byte(out_byte), .page_done(page_done)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // expected stream: kind 0 = data, 1 = spare
    int   q_kind[$];
    int   q_idx[$];
    int   q_byte[$];
    bit   q_last[$];
    int   byte_ctr = 0;

    int  pend_kind = -1;
    int  pend_idx = 0;
    int  pend_byte = 0;
    bit  pend_last = 0;

    function automatic void push(int kind, int idx, bit last);
        q_kind.push_back(kind);
        q_idx.push_back(idx);
        q_byte.push_back((byte_ctr * 37 + 5) & 255);
        q_last.push_back(last);
        byte_ctr++;
    endfunction

    function automatic void build_page(int page, int pkt, int ecc);
        int d = 0;
        int seq = 10;
        int rem = page - 4;
        for (int j = 0; j < 4; j++) push(1, 6 + j, 0);
        while (rem > pkt) begin
            for (int j = 0; j < pkt; j++) begin push(0, d, 0); d++; end
            for (int j = 0; j < ecc; j++) begin push(1, seq, 0); seq++; end
            rem = rem - pkt - ecc;
        end
        for (int j = 0; j < rem; j++) begin push(0, d, 0); d++; end
        for (int j = 0; j < 6; j++) push(1, j, 0);
        for (int j = 0; j < pkt - rem; j++) begin push(0, d, 0); d++; end
        for (int j = 0; j < ecc; j++) begin push(1, seq, j == ecc - 1); seq++; end
    endfunction

    function automatic string tag_of(int kind, int idx, bit last);
        if (kind < 0) return "R9";
        if (last) return "R8";
        if (kind == 0) return "R5";
        if (idx < 6) return "R4";
        if (idx < 10) return "R2";
        return "R3";
    endfunction

    task automatic compare();
        bit ok;
        checks++;
        if (pend_kind < 0)
            ok = !data_stb && !spare_stb && !page_done;
        else if (pend_kind == 0)
            ok = data_stb && !spare_stb && data_idx == 16'(pend_idx) &&
                 out_byte == 8'(pend_byte) && page_done == pend_last;
        else
            ok = spare_stb && !data_stb && spare_idx == 16'(pend_idx) &&
                 out_byte == 8'(pend_byte) && page_done == pend_last;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: got d=%0b di=%0d s=%0b si=%0d b=%0d done=%0b exp kind=%0d idx=%0d b=%0d done=%0b",
                     tag_of(pend_kind, pend_idx, pend_last), cur_tag,
                     data_stb, data_idx, spare_stb, spare_idx, out_byte, page_done,
                     pend_kind, pend_idx, pend_byte, pend_last);
        end
    endtask

    task automatic tick(bit v);
        @(negedge clk);
        compare();
        if (v && q_kind.size() > 0) begin
            pend_kind = q_kind.pop_front();
            pend_idx  = q_idx.pop_front();
            pend_byte = q_byte.pop_front();
            pend_last = q_last.pop_front();
            in_valid  = 1'b1;
            in_byte   = 8'(pend_byte);
        end else begin
            pend_kind = -1;
            pend_last = 0;
            in_valid  = 1'b0;
        end
    endtask

    task automatic run_stream(int gap_every);
        int n = 0;
        while (q_kind.size() > 0) begin
            n++;
            if (gap_every > 0 && (n % gap_every) == 0) tick(0);
            else tick(1);
        end
        tick(0);
        tick(0);
    endtask

    task automatic do_reset(int page, int pkt, int ecc);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;          // ignored while in reset (R1)
        cfg_page_bytes = 16'(page);
        cfg_pkt_bytes  = 16'(pkt);
        cfg_ecc_bytes  = 16'(ecc);
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        pend_kind = -1;
        pend_last = 0;
        @(negedge clk);
        cur_tag = "R1";
        compare();
    endtask

    initial begin
        // R1: reset state
        do_reset(32, 8, 3);
        // R2 R3 R4 R5 R6 R8: two full packets, split last packet (head 6, tail 2)
        cur_tag = "R6";
        build_page(32, 8, 3);
        run_stream(0);
        // R9: same layout with idle gaps
        cur_tag = "R9";
        build_page(32, 8, 3);
        run_stream(3);
        // R7: head equals a whole packet, marker then last ECC directly
        do_reset(40, 16, 4);
        cur_tag = "R7";
        build_page(40, 16, 4);
        run_stream(0);
        // R10: back-to-back pages, done followed at once by next metadata
        do_reset(64, 16, 2);
        cur_tag = "R10";
        build_page(64, 16, 2);
        build_page(64, 16, 2);
        run_stream(0);
        // R10 with gaps and R6 split (head 6, tail 10)
        cur_tag = "R10";
        build_page(64, 16, 2);
        build_page(64, 16, 2);
        run_stream(5);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule